// File: doc/BRIEF.md
# Serial Interface Status Flag Controller

This block keeps the status flags and the data-register handshake of a byte-wide serial port. A host reaches four byte registers over a plain strobe bus. Bit timing and line shifting live elsewhere. That outside logic hands this block each received byte with a one-cycle strobe, and gives it a one-cycle strobe when a character time has elapsed. In return the block offers a transmit byte with a one-cycle send pulse.

Receive flags are cleared only by a two-step sequence. A status read first records which receive flags are up. A data read then drops exactly those flags. If a new byte lands between the two reads, the recorded set is thrown away, so the host cannot lose an overrun it never saw. Transmit flags are cleared when a byte is handed out. They come back at the end of its character time. A single interrupt line combines each flag with its enable.

Top module: `sci_flag_ctl`

## Requirements
- R1: After reset the status register (address 2) reads 0xC0, with transmit-empty (bit 7) and transmit-complete (bit 6) set and every receive flag clear. Both control registers read 0x00 and irq is low.
- R2: Control 1 (address 0) and control 2 (address 1) read back the last byte written to them. The control 2 bits are: 7 transmit-empty interrupt enable, 6 transmit-complete interrupt enable, 5 receive interrupt enable, 4 idle interrupt enable, 3 transmit enable, 2 receive enable, 1 wake-up, 0 send-break.
- R3: A receive strobe while receive is enabled sets receive-full (status bit 5) and stores the byte. The data register (address 3) returns that byte.
- R4: A byte that arrives while receive-full is set also sets overrun (status bit 3), and the newer byte replaces the stored one.
- R5: A data read clears exactly the receive flags that were captured by the last status read. A data read with no capture pending leaves the flags unchanged.
- R6: A byte arrival discards a pending capture, so the next data read clears nothing.
- R7: A receive strobe while receive enable is clear has no effect.
- R8: A data write while transmit-empty is set and the transmitter is enabled and idle sends the byte straight away. tx_send pulses on the next cycle with tx_byte equal to the byte, and transmit-empty and transmit-complete both read 0.
- R9: A data write while transmit-empty is clear is dropped and never sent.
- R10: A character-done strobe ends a transmission only while transmit enable is set. It then sets transmit-empty and transmit-complete again. While transmit enable is clear, the transmission stays in progress.
- R11: A data write while the transmitter is disabled is held, transmit-empty stays set, and a later write replaces the held byte. The held byte is sent once transmit enable is set.
- R12: irq is high when any of these pairs is true: transmit-empty with its enable, transmit-complete with its enable, receive-full or overrun with the receive interrupt enable, or idle with its enable. The idle, noise and framing flags (status bits 4, 2, 1) always read 0 here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 ctrl1, 1 ctrl2, 2 status, 3 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected register |
| rx_strobe | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| char_tick | input | 1 | One character time has elapsed |
| tx_byte | output | 8 | Byte being sent |
| tx_send | output | 1 | One-cycle pulse: tx_byte starts transmission |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at three corners. The first is a byte arriving between the status read and the data read: a design that keeps the stale capture would silently drop the new receive-full and overrun flags. The second is a data write while a byte is still in flight: a design that buffered it anyway would emit a second tx_send after the next character-done strobe. The third covers a character-done strobe with the transmitter disabled, and bytes written while disabled. A wrong design would either restore the transmit flags early or send the first held byte instead of the last one. A long random mix of bus traffic, receive strobes and character strobes is checked cycle by cycle against a bench model of the flags and irq.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_CTRL1 = 2'd0;
  localparam logic [REG_AW-1:0] A_CTRL2 = 2'd1;
  localparam logic [REG_AW-1:0] A_STAT  = 2'd2;
  localparam logic [REG_AW-1:0] A_DATA  = 2'd3;

  // status bit positions
  localparam int S_TXE = 7;
  localparam int S_TXC = 6;
  localparam int S_RXF = 5;
  localparam int S_IDL = 4;
  localparam int S_OVR = 3;
  // control 2 bit positions
  localparam int C_TXEIE = 7;
  localparam int C_TXCIE = 6;
  localparam int C_RXIE  = 5;
  localparam int C_IDLIE = 4;
  localparam int C_TXEN  = 3;
  localparam int C_RXEN  = 2;

  function automatic logic [7:0] pack_status(input logic txe, input logic txc,
                                             input logic rxf, input logic ovr);
    logic [7:0] s;
    s = '0;
    s[S_TXE] = txe;
    s[S_TXC] = txc;
    s[S_RXF] = rxf;
    s[S_OVR] = ovr;
    return s;
  endfunction

  function automatic logic irq_of(input logic [7:0] stat, input logic [7:0] c2);
    return (stat[S_TXE] & c2[C_TXEIE]) | (stat[S_TXC] & c2[C_TXCIE]) |
           ((stat[S_RXF] | stat[S_OVR]) & c2[C_RXIE]) | (stat[S_IDL] & c2[C_IDLIE]);
  endfunction
endpackage

// File: rtl/sci_tx_ctl.sv
module sci_tx_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              char_tick,
  output logic              txe,
  output logic              txc,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_send
);
  logic              busy, pend;
  logic [DATA_W-1:0] pbuf;

  // named events for the assertions
  logic done_ev, accept, launch_wr, hold_wr, launch_pend;
  assign done_ev     = busy & char_tick & tx_en;
  assign accept      = wr_data & txe;
  assign launch_wr   = accept & tx_en & ~busy;
  assign hold_wr     = accept & ~(tx_en & ~busy);
  assign launch_pend = tx_en & pend & ~busy & ~accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe <= 1'b1; txc <= 1'b1; busy <= 1'b0; pend <= 1'b0;
      pbuf <= '0; tx_byte <= '0; tx_send <= 1'b0;
    end else begin
      tx_send <= 1'b0;
      if (done_ev) begin
        busy <= 1'b0; txe <= 1'b1; txc <= 1'b1;
      end else if (launch_wr || launch_pend) begin
        tx_byte <= launch_wr ? wdata : pbuf;
        tx_send <= 1'b1;
        busy    <= 1'b1;
        txe     <= 1'b0;
        txc     <= 1'b0;
        pend    <= 1'b0;
      end else if (hold_wr) begin
        pend <= 1'b1;
        pbuf <= wdata;
      end
    end
  end

  p_send_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |-> (!txe && !txc));
  p_wr_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !txe) |=> !tx_send);
  p_tick_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && char_tick && tx_en) |=> (txe && txc));
  p_tick_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_en) |=> !txe);
endmodule

// File: rtl/sci_rx_ctl.sv
module sci_rx_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rd_status,
  input  logic              rd_data,
  output logic              rxf,
  output logic              ovr,
  output logic [DATA_W-1:0] rx_buf
);
  // capture mask: bit 1 receive-full, bit 0 overrun
  logic [1:0] cap;
  logic       acc;
  assign acc = rx_strobe & rx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxf <= 1'b0; ovr <= 1'b0; rx_buf <= '0; cap <= '0;
    end else if (acc) begin
      ovr    <= ovr | rxf;
      rxf    <= 1'b1;
      rx_buf <= rx_byte;
      cap    <= '0;
    end else if (rd_status) begin
      cap <= {rxf, ovr};
    end else if (rd_data) begin
      rxf <= rxf & ~cap[1];
      ovr <= ovr & ~cap[0];
      cap <= '0;
    end
  end

  p_arrival_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rxf && rx_buf == $past(rx_byte)));
  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rxf) |=> ovr);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !acc && cap[1]) |=> !rxf);
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !acc && cap == 2'b00) |=> ($stable(rxf) && $stable(ovr)));
  p_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !rx_en) |=> $stable(rx_buf));
endmodule

// File: rtl/sci_flag_ctl.sv
module sci_flag_ctl
  import sci_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              char_tick,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_send,
  output logic              irq
);
  logic [7:0] ctrl1, ctrl2, stat;
  logic txe, txc, rxf, ovr;
  logic [DATA_W-1:0] rx_buf;
  logic rd_status, rd_data, wr_data;

  assign rd_status = bus_rd & (bus_addr == A_STAT);
  assign rd_data   = bus_rd & (bus_addr == A_DATA);
  assign wr_data   = bus_wr & (bus_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl1 <= '0; ctrl2 <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL1) ctrl1 <= bus_wdata[7:0];
      if (bus_addr == A_CTRL2) ctrl2 <= bus_wdata[7:0];
    end
  end

  sci_tx_ctl #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(ctrl2[C_TXEN]), .wr_data(wr_data),
    .wdata(bus_wdata), .char_tick(char_tick), .txe(txe), .txc(txc),
    .tx_byte(tx_byte), .tx_send(tx_send));

  sci_rx_ctl #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(ctrl2[C_RXEN]), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .rd_status(rd_status), .rd_data(rd_data),
    .rxf(rxf), .ovr(ovr), .rx_buf(rx_buf));

  assign stat = pack_status(txe, txc, rxf, ovr);
  assign irq  = irq_of(stat, ctrl2);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL1: bus_rdata[7:0] = ctrl1;
      A_CTRL2: bus_rdata[7:0] = ctrl2;
      A_STAT:  bus_rdata[7:0] = stat;
      default: bus_rdata      = rx_buf;
    endcase
  end

  p_irq_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf && ctrl2[C_RXIE]) |-> irq);
  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL2) |=> (ctrl2 == $past(bus_wdata[7:0])));
endmodule

// File: tb/sci_flag_ctl_tb.sv
module sci_flag_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 0, bus_wr = 0, rx_strobe = 0, char_tick = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, rx_byte = 0;
  logic [7:0] bus_rdata, tx_byte;
  logic tx_send, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sci_flag_ctl dut_i (.clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .char_tick(char_tick),
    .tx_byte(tx_byte), .tx_send(tx_send), .irq(irq));

  // bench model
  bit m_txe = 1, m_txc = 1, m_rxf = 0, m_ovr = 0, m_busy = 0, m_pend = 0;
  bit [1:0] m_cap = 0;
  bit [7:0] m_rxbuf = 0, m_pbuf = 0, m_c1 = 0, m_c2 = 0;

  function automatic bit [7:0] m_status();
    return {m_txe, m_txc, m_rxf, 1'b0, m_ovr, 3'b000};
  endfunction
  function automatic bit m_irq();
    return (m_txe & m_c2[7]) | (m_txc & m_c2[6]) | ((m_rxf | m_ovr) & m_c2[5]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input bit rd, input bit wr, input bit [1:0] a,
                    input bit [7:0] wd, input bit rxs, input bit [7:0] rb, input bit tk);
    bit [7:0] exp_rd;
    bit exp_send;
    bit [7:0] exp_byte;
    bit txen, rxen, acc, accept;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_strobe = rxs; rx_byte = rb; char_tick = tk;
    #1;
    case (a)
      2'd0: exp_rd = m_c1;
      2'd1: exp_rd = m_c2;
      2'd2: exp_rd = m_status();
      default: exp_rd = m_rxbuf;
    endcase
    if (rd) chk(tag, bus_rdata, exp_rd);
    // model next state from old values
    txen = m_c2[3]; rxen = m_c2[2];
    exp_send = 0; exp_byte = 0;
    accept = wr && a == 2'd3 && m_txe;
    if (m_busy && tk && txen) begin
      m_busy = 0; m_txe = 1; m_txc = 1;
    end else if (accept && txen && !m_busy) begin
      exp_send = 1; exp_byte = wd; m_busy = 1; m_txe = 0; m_txc = 0; m_pend = 0;
    end else if (accept) begin
      m_pend = 1; m_pbuf = wd;
    end else if (txen && m_pend && !m_busy) begin
      exp_send = 1; exp_byte = m_pbuf; m_busy = 1; m_txe = 0; m_txc = 0; m_pend = 0;
    end
    acc = rxs && rxen;
    if (acc) begin
      m_ovr = m_ovr | m_rxf; m_rxf = 1; m_rxbuf = rb; m_cap = 0;
    end else if (rd && a == 2'd2) begin
      m_cap = {m_rxf, m_ovr};
    end else if (rd && a == 2'd3) begin
      m_rxf = m_rxf & ~m_cap[1]; m_ovr = m_ovr & ~m_cap[0]; m_cap = 0;
    end
    if (wr && a == 2'd0) m_c1 = wd;
    if (wr && a == 2'd1) m_c2 = wd;
    @(posedge clk);
    #1;
    bus_rd = 0; bus_wr = 0; rx_strobe = 0; char_tick = 0;
    chk(tag, tx_send, exp_send);
    if (exp_send) chk(tag, tx_byte, exp_byte);
    chk("R12 irq", irq, m_irq());
  endtask

  task automatic rds(input string tag); op(tag, 1, 0, 2'd2, 0, 0, 0, 0); endtask
  task automatic rdd(input string tag); op(tag, 1, 0, 2'd3, 0, 0, 0, 0); endtask
  task automatic wrr(input string tag, input bit [1:0] a, input bit [7:0] d);
    op(tag, 0, 1, a, d, 0, 0, 0);
  endtask
  task automatic rxb(input string tag, input bit [7:0] b); op(tag, 0, 0, 0, 0, 1, b, 0); endtask
  task automatic tick(input string tag); op(tag, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    rds("R1 status"); chk("R1 status value", bus_rdata, 8'hC0);
    op("R1 ctrl1", 1, 0, 2'd0, 0, 0, 0, 0);
    op("R1 ctrl2", 1, 0, 2'd1, 0, 0, 0, 0);
    // R7 receive disabled
    rxb("R7", 8'h9E); rds("R7 status");
    // R2 control readback
    wrr("R2", 2'd0, 8'h5A); op("R2 ctrl1", 1, 0, 2'd0, 0, 0, 0, 0);
    wrr("R2", 2'd1, 8'h04); op("R2 ctrl2", 1, 0, 2'd1, 0, 0, 0, 0);
    // R3 arrival and readout
    rxb("R3", 8'h3C); rds("R3 status"); rdd("R3 data"); rds("R5 cleared");
    // R4 overrun
    rxb("R4", 8'h11); rxb("R4", 8'h22); rds("R4 status"); rdd("R4 data"); rds("R5 cleared");
    // R5 data read without capture
    rxb("R5", 8'h33); rdd("R5 no capture"); rds("R5 still set"); rdd("R5 data"); rds("R5 clear");
    // R6 arrival discards capture
    rxb("R6", 8'h44); rds("R6 capture"); rxb("R6", 8'h55); rdd("R6 data");
    rds("R6 flags kept"); rdd("R6 clear"); rds("R6 clear status");
    // R8 immediate send
    wrr("R8", 2'd1, 8'h0C); wrr("R8 send", 2'd3, 8'hA5); rds("R8 status");
    // R9 write while busy dropped
    wrr("R9 dropped", 2'd3, 8'h77); tick("R10 done"); rds("R10 status");
    tick("R9 no late send"); op("R9 idle", 0, 0, 0, 0, 0, 0, 0);
    // R10 tick with transmit disabled
    wrr("R10 send", 2'd3, 8'h12); wrr("R10", 2'd1, 8'h04); tick("R10 frozen");
    rds("R10 still busy"); wrr("R10", 2'd1, 8'h0C); tick("R10 done"); rds("R10 flags");
    // R11 held bytes while disabled
    wrr("R11", 2'd1, 8'h04); wrr("R11 hold", 2'd3, 8'h61); wrr("R11 replace", 2'd3, 8'h62);
    rds("R11 txe kept"); wrr("R11", 2'd1, 8'h0C); op("R11 sent", 0, 0, 0, 0, 0, 0, 0);
    tick("R11 done");
    // R12 interrupt pairs
    wrr("R12", 2'd1, 8'h8C); wrr("R12", 2'd1, 8'h4C); wrr("R12", 2'd1, 8'h24);
    rxb("R12 rx", 8'h0F); rds("R12"); rdd("R12");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      bit [7:0] d;
      k = int'($urandom % 9);
      d = 8'($urandom);
      case (k)
        0: rds("R5 random status");
        1: rdd("R3 random data");
        2: wrr("R8 random write", 2'd3, d);
        3: wrr("R2 random ctrl2", 2'd1, d | 8'h04);
        4: rxb("R4 random rx", d);
        5: tick("R10 random tick");
        6: op("R6 random rx+read", 1, 0, 2'd3, 0, 1, d, 0);
        7: op("R6 random status+rx", 1, 0, 2'd2, 0, 1, d, 1);
        default: op("R11 random ctrl+tick", 0, 1, 2'd1, d, 0, 0, 1);
      endcase
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule